// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that sits in front of a 10-bit successive-approximation converter core. A set of plain configuration inputs chooses whether the block is enabled, which of four trigger sources may start a conversion, which input channel is converted, how long the input is sampled and how the result is aligned. When an accepted trigger arrives, the block runs a sampling phase of a programmable length. It then sends a one-cycle start pulse to the analog core and waits for the core's done strobe, which carries the 10-bit value.

The finished value is placed in a 16-bit result word, either left- or right-justified with zero fill. The word is offered on a valid/ready output. `res_valid` rises in the cycle after the result is loaded, and a handshake (`res_valid && res_ready` at a clock edge) clears it. The block never stalls on back-pressure. A result that has not been taken is replaced by the next one, and `res_valid` stays high. When a load and a handshake fall on the same edge, the load wins: the new word is presented with `res_valid` high. The `busy` output serves as the read-back of the software start bit. It stays high for the whole of a conversion, whatever source started it.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset `busy`, `core_start`, `res_valid` and `res_data` are all 0.
- R2: While `cfg_enable` is 0, no trigger of any source starts a conversion, and `busy` stays 0.
- R3: Only the source chosen by `cfg_trig_sel` starts a conversion: code 0 is `sw_start`, and code k (1..3) is `hw_trig[k-1]`. Pulses on the other sources are ignored.
- R4: With `cfg_trig_sel` = 0 and the block enabled, a one-cycle `sw_start` pulse starts a conversion.
- R5: `busy` goes to 1 at the edge that accepts a trigger, stays 1 through sampling and conversion, and returns to 0 at the edge where `core_done` is seen.
- R6: `cur_ch` shows the value of `cfg_start_ch` that was captured at the accepting edge.
- R7: Sampling lasts 2*(code+1) cycles for `cfg_smp_sel` = code. `core_start` is high in exactly one cycle, 2*(code+1) cycles after the accepting edge.
- R8: With `cfg_left_just` = 1, the result word is {data, 6'b0}: the data occupies bits 15:6.
- R9: With `cfg_left_just` = 0, the result word is {6'b0, data}: the data occupies bits 9:0.
- R10: The result word changes only when `core_done` arrives while the block waits on the core. A `core_done` pulse at any other time is ignored.
- R11: A trigger that arrives while a conversion is running is ignored. It produces no second `core_start` pulse and no second result.
- R12: Clearing `cfg_enable` during a conversion returns the block to idle at the next edge, and the result word and `res_valid` keep their values.
- R13: `res_valid` is set when the result word is loaded and cleared by a handshake. A load on the same edge as a handshake leaves `res_valid` at 1 with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable; 0 aborts and holds idle |
| cfg_trig_sel | input | 2 | Trigger source select (0 = software) |
| cfg_start_ch | input | 3 | Channel to convert |
| cfg_smp_sel | input | 3 | Sample-time code |
| cfg_left_just | input | 1 | 1 = left-justified result, 0 = right |
| sw_start | input | 1 | Software start write pulse |
| hw_trig | input | 3 | Hardware trigger pulses, sources 1..3 |
| busy | output | 1 | Start bit read-back, 1 while converting |
| cur_ch | output | 3 | Channel under conversion |
| core_start | output | 1 | One-cycle start pulse to analog core |
| core_done | input | 1 | Done strobe from analog core |
| core_data | input | 10 | Converted value, valid with core_done |
| res_data | output | 16 | Aligned result word |
| res_valid | output | 1 | Result word holds an untaken value |
| res_ready | input | 1 | Consumer takes the result word |

## Verification
Two pairs of events can land on the same edge: loading a new result together with the handshake that clears `res_valid`, and the core's done strobe together with an enable drop. For the first pair, the bench holds `res_ready` low so that one result stays pending. It then raises `res_ready` exactly in the cycle of the next `core_done`, and expects `res_valid` to stay high with the new word, then to clear one cycle later. For the second pair, enable is dropped during sampling and a stray done strobe follows. The bench judges this case by `busy` falling at once and by the old result word and `res_valid` being unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

  // Places a DW-bit value in an RW-bit word, left or right, zero filled.
  function automatic logic [15:0] align_word(input logic [9:0] d, input logic left);
    logic [15:0] w;
    w = left ? {d, 6'b0} : {6'b0, d};
    return w;
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int TSEL_W = 2,
  localparam int NSRC  = 1 << TSEL_W,
  localparam int NHW   = NSRC - 1
) (
  input  logic [TSEL_W-1:0] sel,
  input  logic              sw_start,
  input  logic [NHW-1:0]    hw_trig,
  output logic              trig
);
  logic [NSRC-1:0] src_vec;

  assign src_vec = {hw_trig, sw_start};
  assign trig    = src_vec[sel];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SMP_W = 3,
  parameter int CH_W  = 3,
  localparam int CNT_W = SMP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             trig,
  input  logic [SMP_W-1:0] smp_sel,
  input  logic [CH_W-1:0]  start_ch,
  input  logic             core_done,
  output logic             busy,
  output logic [CH_W-1:0]  cur_ch,
  output logic             core_start,
  output logic             load
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign busy = (state != ST_IDLE);
  assign load = enable && (state == ST_CONV) && core_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cur_ch     <= '0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (trig) begin
            state  <= ST_SAMPLE;
            cnt    <= {smp_sel, 1'b1};   // 2*(code+1) - 1
            cur_ch <= start_ch;
          end
          ST_SAMPLE: begin
            if (cnt == '0) begin
              state      <= ST_CONV;
              core_start <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_CONV: if (core_done) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        left,
  input  logic [9:0]  data_in,
  input  logic        ready,
  output logic [15:0] word,
  output logic        valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      word  <= align_word(data_in, left);
      valid <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int TSEL_W = 2,
  parameter int CH_W   = 3,
  parameter int SMP_W  = 3,
  localparam int NHW   = (1 << TSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [TSEL_W-1:0] cfg_trig_sel,
  input  logic [CH_W-1:0]   cfg_start_ch,
  input  logic [SMP_W-1:0]  cfg_smp_sel,
  input  logic              cfg_left_just,
  input  logic              sw_start,
  input  logic [NHW-1:0]    hw_trig,
  output logic              busy,
  output logic [CH_W-1:0]   cur_ch,
  output logic              core_start,
  input  logic              core_done,
  input  logic [9:0]        core_data,
  output logic [15:0]       res_data,
  output logic              res_valid,
  input  logic              res_ready
);
  logic trig_sel_hit;
  logic load_res;

  adc_trig_sel #(.TSEL_W(TSEL_W)) u_trig (
    .sel      (cfg_trig_sel),
    .sw_start (sw_start),
    .hw_trig  (hw_trig),
    .trig     (trig_sel_hit)
  );

  adc_seq_fsm #(.SMP_W(SMP_W), .CH_W(CH_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .trig       (trig_sel_hit),
    .smp_sel    (cfg_smp_sel),
    .start_ch   (cfg_start_ch),
    .core_done  (core_done),
    .busy       (busy),
    .cur_ch     (cur_ch),
    .core_start (core_start),
    .load       (load_res)
  );

  adc_result_reg u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_res),
    .left    (cfg_left_just),
    .data_in (core_data),
    .ready   (res_ready),
    .word    (res_data),
    .valid   (res_valid)
  );
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_enable,
  input logic        busy,
  input logic        core_start,
  input logic        core_done,
  input logic [15:0] res_data,
  input logic        res_valid,
  input logic        res_ready
);
  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !busy);

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  // R5
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> busy);

  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_data[5:0] == 6'd0) || (res_data[15:10] == 6'd0));

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_done |=> $stable(res_data));

  // R13
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !core_done) |=> !res_valid);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .busy       (busy),
  .core_start (core_start),
  .core_done  (core_done),
  .res_data   (res_data),
  .res_valid  (res_valid),
  .res_ready  (res_ready)
);

// File: tb/tb_adc_conv_ctrl.sv
`timescale 1ns/1ps
module tb_adc_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_trig_sel = '0;
  logic [2:0]  cfg_start_ch = '0;
  logic [2:0]  cfg_smp_sel = '0;
  logic        cfg_left_just = 1'b0;
  logic        sw_start = 1'b0;
  logic [2:0]  hw_trig = '0;
  logic        busy;
  logic [2:0]  cur_ch;
  logic        core_start;
  logic        core_done = 1'b0;
  logic [9:0]  core_data = '0;
  logic [15:0] res_data;
  logic        res_valid;
  logic        res_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_en = 1'b1;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  adc_conv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_trig_sel(cfg_trig_sel),
    .cfg_start_ch(cfg_start_ch), .cfg_smp_sel(cfg_smp_sel), .cfg_left_just(cfg_left_just),
    .sw_start(sw_start), .hw_trig(hw_trig), .busy(busy), .cur_ch(cur_ch),
    .core_start(core_start), .core_done(core_done), .core_data(core_data),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(logic [9:0] d, bit left);
    return left ? {d, 6'b0} : {6'b0, d};
  endfunction

  // Monitor: every accepted result is compared with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && mon_en && res_valid && res_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: actual %0h expected none", res_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (res_data !== e) begin
          n_bad++;
          $display("FAIL R8/R9: actual %0h expected %0h", res_data, e);
        end
      end
    end
  end

  task automatic pulse_src(int src);
    if (src == 0) sw_start = 1'b1;
    else hw_trig[src-1] = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    hw_trig = '0;
  endtask

  // Driver: start, time the sampling phase, answer as the core, push expected.
  task automatic run_conv(int src, int code, int ch, bit left, logic [9:0] d,
                          bit push, bit retrig);
    int k;
    @(negedge clk);
    cfg_enable = 1'b1; cfg_trig_sel = 2'(src); cfg_smp_sel = 3'(code);
    cfg_start_ch = 3'(ch); cfg_left_just = left;
    pulse_src(src);
    check("R5 busy after accept", 32'(busy), 1);
    check("R6 cur_ch", 32'(cur_ch), 32'(ch));
    k = 0;
    while (!core_start && k < 64) begin
      @(negedge clk);
      k++;
    end
    check("R7 sample cycles", 32'(k), 32'(2 * (code + 1)));
    if (retrig) pulse_src(src);          // R11 trigger during conversion
    else @(negedge clk);
    check("R7 start is one cycle", 32'(core_start), 0);
    check("R5 busy while waiting", 32'(busy), 1);
    if (push) exp_q.push_back(fmt(d, left));
    core_done = 1'b1; core_data = d;
    @(negedge clk);
    core_done = 1'b0;
    check("R5 busy after done", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 core_start", 32'(core_start), 0);
    check("R1 res_valid", 32'(res_valid), 0);
    check("R1 res_data", 32'(res_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disabled, every source pulsed
    cfg_enable = 1'b0;
    for (int s = 0; s < 4; s++) begin
      cfg_trig_sel = 2'(s);
      pulse_src(s);
      check("R2 disabled ignores trigger", 32'(busy), 0);
    end

    // R3: select source 2, pulse every other source
    cfg_enable = 1'b1; cfg_trig_sel = 2'd2;
    pulse_src(0); check("R3 sw ignored", 32'(busy), 0);
    pulse_src(1); check("R3 hw0 ignored", 32'(busy), 0);
    pulse_src(3); check("R3 hw2 ignored", 32'(busy), 0);

    // R4, R8, R9: conversions from each source, both alignments
    run_conv(0, 0, 5, 1'b0, 10'h3A5, 1'b1, 1'b0);
    run_conv(1, 3, 2, 1'b1, 10'h3FF, 1'b1, 1'b0);
    run_conv(2, 7, 7, 1'b0, 10'h001, 1'b1, 1'b0);
    run_conv(3, 1, 0, 1'b1, 10'h155, 1'b1, 1'b0);

    // R11: retrigger during conversion, then confirm no second start
    run_conv(2, 2, 4, 1'b0, 10'h2AA, 1'b1, 1'b1);
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (core_start || busy) seen = 1'b1;
    end
    check("R11 no second conversion", 32'(seen), 0);

    // R12: abort during sampling, then a stray done strobe (R10)
    @(negedge clk);
    cfg_trig_sel = 2'd1; cfg_smp_sel = 3'd7; cfg_left_just = 1'b1;
    pulse_src(1);
    check("R12 started", 32'(busy), 1);
    cfg_enable = 1'b0;
    @(negedge clk);
    check("R12 abort to idle", 32'(busy), 0);
    core_done = 1'b1; core_data = 10'h0F0;
    @(negedge clk);
    core_done = 1'b0;
    @(negedge clk);
    check("R12 word kept", 32'(res_data), 32'(fmt(10'h2AA, 1'b0)));
    check("R10 stray done ignored", 32'(res_valid), 0);

    // R13: load and handshake on the same edge
    mon_en = 1'b0; res_ready = 1'b0;
    run_conv(0, 0, 1, 1'b0, 10'h111, 1'b0, 1'b0);
    check("R13 valid held", 32'(res_valid), 1);
    check("R13 first word", 32'(res_data), 32'h0111);
    @(negedge clk);
    cfg_trig_sel = 2'd0; cfg_smp_sel = 3'd0; cfg_left_just = 1'b1;
    pulse_src(0);
    while (!core_start) @(negedge clk);
    @(negedge clk);
    core_done = 1'b1; core_data = 10'h222; res_ready = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    check("R13 load wins", 32'(res_valid), 1);
    check("R13 new word", 32'(res_data), 32'(fmt(10'h222, 1'b1)));
    @(negedge clk);
    check("R13 handshake clears", 32'(res_valid), 0);

    check("R8/R9 scoreboard drained", 32'(exp_q.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule